// File: doc/BRIEF.md
# Four-Bank Low-Order Interleaved Read Path

This block serves byte reads from a memory spread over four banks, with consecutive addresses going to consecutive banks. A 15-bit read address is split in two: the two least significant bits name a bank, and the remaining thirteen bits name a row that is common to all four banks. Each bank feeds a holding register, and the four holding registers together keep one complete four-byte row. A multiplexer driven by the bank-select bits picks the returned byte from them.

A request is a one-cycle strobe with an address. The block compares the requested row with the row now in the holding registers. When they are equal, the byte comes out of the registers through the multiplexer and no bank is read. When they differ, all four banks are read at the new row in parallel, the holding registers are refilled, and then the byte is returned. A done pulse marks the cycle in which the returned byte is valid. The bank arrays are modelled inside the block. A separate preload port lets a test environment fill them. Storage depth is a parameter, and rows wrap onto it modulo the depth.

Top module: `ilv_read_top`

## Requirements
- R1: While reset is held and after its release, with no request, `done_o` stays 0.
- R2: Address bits [1:0] select the bank (0 to 3), and bits [14:2] select the row. The byte returned for address {row, bank} is the byte last written to that bank at that row.
- R3: A request sampled at rising edge k that misses raises `done_o` for one cycle after edge k+1, with the requested byte on `data_o`.
- R4: A request sampled at edge k that hits raises `done_o` after edge k. The byte comes from the holding registers without a bank read, so a preload write to that row after the row was fetched is not visible.
- R5: A miss loads all four banks of the new row, so following requests to any bank of that row are hits.
- R6: The first request after reset is always a miss, even for row 0.
- R7: A request that arrives while a miss is being served (the cycle after a miss was accepted) is dropped. It produces no done pulse and does not change the held row.
- R8: `done_o` is high exactly once for each accepted request. Hits strobed on consecutive cycles give done on consecutive cycles.
- R9: When `pre_we_i` is high at a rising edge, `pre_data_i` is written to bank `pre_bank_i` at row `pre_row_i` modulo the storage depth. A later miss on that row returns the new byte.
- R10: The row comparison uses all thirteen row bits. Rows that differ only in bit 12 are treated as different and cause a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Read request strobe |
| addr_i | input | 15 | Read address: [14:2] row, [1:0] bank |
| data_o | output | 8 | Returned byte, valid while done_o is high |
| done_o | output | 1 | One-cycle completion flag |
| pre_we_i | input | 1 | Preload write enable for the bank arrays |
| pre_row_i | input | 13 | Preload row |
| pre_bank_i | input | 2 | Preload bank select |
| pre_data_i | input | 8 | Preload byte |

## Verification
The bench goes after the cold start, where a design that trusted its zeroed holding registers would answer row 0 in one cycle with a zero byte. It also changes a bank behind a held row. A design that re-read the banks on a hit would return the new byte instead of the stale one. Requests strobed during a fetch expose a design that queues or overwrites the pending row: either it gives an extra done, or it turns the next request to the old row into a miss. A pair of rows that differ only in the top row bit catches a narrowed tag compare, which would call the second request a hit and return a byte from the wrong row.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } ilv_state_e;
endpackage

// File: rtl/ilv_bank.sv
// One bank array with its holding register on the read side.
module ilv_bank #(
  parameter int DATA_W = 8,
  parameter int ROW_W  = 13,
  parameter int DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [DATA_W-1:0] hold_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] hold_q;

  // rows wrap onto the implemented depth
  assign wr_idx = IDX_W'(rd_row_mod(wr_row));
  assign rd_idx = IDX_W'(rd_row_mod(rd_row));

  function automatic int rd_row_mod(input logic [ROW_W-1:0] r);
    return int'(r) % DEPTH;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (rd_en) begin
      hold_q <= mem[rd_idx];
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/ilv_ctrl.sv
// Row tag, request acceptance and completion timing.
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             fetch_o,
  output logic [ROW_W-1:0] fetch_row_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             done_o
);
  ilv_state_e       state_q, state_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             valid_q, valid_d;
  logic             done_q, done_d;
  logic             accept;
  logic             hit;

  assign accept = req_i && (state_q == ST_IDLE);
  assign hit    = accept && valid_q && (row_i == row_q);

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    sel_d   = sel_q;
    valid_d = valid_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          sel_d = sel_i;
          if (hit) begin
            done_d = 1'b1;
          end else begin
            row_d   = row_i;
            state_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        valid_d = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      sel_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      sel_q   <= sel_d;
      valid_q <= valid_d;
      done_q  <= done_d;
    end
  end

  assign fetch_o     = (state_q == ST_FETCH);
  assign fetch_row_o = row_q;
  assign sel_o       = sel_q;
  assign done_o      = done_q;

  // R4: a hit finishes on the next edge and leaves the block idle
  a_r4_hit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (done_q && state_q == ST_IDLE));

  // R3: a fetch cycle is always followed by completion with a valid row
  a_r3_fetch_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |=> (done_q && valid_q && state_q == ST_IDLE));

  // R7: nothing arriving during a fetch disturbs the pending row or select
  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |=> ($stable(row_q) && $stable(sel_q)));

  // R6: with no valid row every accepted request goes to the banks
  a_r6_cold_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !valid_q) |=> (state_q == ST_FETCH && !done_q));

  // R8: completion only follows a hit or a fetch
  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && state_q == ST_IDLE) |=> !done_q);
endmodule

// File: rtl/ilv_outmux.sv
// Picks one holding register by bank select.
module ilv_outmux #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 2,
  parameter int NBANK  = 4
) (
  input  logic [NBANK-1:0][DATA_W-1:0] words_i,
  input  logic [SEL_W-1:0]             sel_i,
  output logic [DATA_W-1:0]            word_o
);
  always_comb begin
    word_o = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (sel_i == SEL_W'(i)) begin
        word_o = words_i[i];
      end
    end
  end
endmodule

// File: rtl/ilv_read_top.sv
module ilv_read_top #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int SEL_W      = 2,
  parameter int BANK_DEPTH = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [DATA_W-1:0]       data_o,
  output logic                    done_o,
  input  logic                    pre_we_i,
  input  logic [ADDR_W-SEL_W-1:0] pre_row_i,
  input  logic [SEL_W-1:0]        pre_bank_i,
  input  logic [DATA_W-1:0]       pre_data_i
);
  localparam int ROW_W = ADDR_W - SEL_W;
  localparam int NBANK = 1 << SEL_W;

  logic [1:0]                    rsync_q;
  logic                          rst_n_s;
  logic [ROW_W-1:0]              req_row;
  logic [SEL_W-1:0]              req_sel;
  logic                          fetch;
  logic [ROW_W-1:0]              fetch_row;
  logic [SEL_W-1:0]              sel_q;
  logic [NBANK-1:0][DATA_W-1:0]  hold;

  // reset asserts at once and releases on the second edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rsync_q[1];

  assign req_row = addr_i[ADDR_W-1:SEL_W];
  assign req_sel = addr_i[SEL_W-1:0];

  ilv_ctrl #(
    .ROW_W(ROW_W),
    .SEL_W(SEL_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_i      (req_i),
    .row_i      (req_row),
    .sel_i      (req_sel),
    .fetch_o    (fetch),
    .fetch_row_o(fetch_row),
    .sel_o      (sel_q),
    .done_o     (done_o)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_we;
    assign bank_we = pre_we_i && (pre_bank_i == SEL_W'(b));

    ilv_bank #(
      .DATA_W(DATA_W),
      .ROW_W (ROW_W),
      .DEPTH (BANK_DEPTH)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .wr_en  (bank_we),
      .wr_row (pre_row_i),
      .wr_data(pre_data_i),
      .rd_en  (fetch),
      .rd_row (fetch_row),
      .hold_o (hold[b])
    );
  end

  ilv_outmux #(
    .DATA_W(DATA_W),
    .SEL_W (SEL_W),
    .NBANK (NBANK)
  ) u_mux (
    .words_i(hold),
    .sel_i  (sel_q),
    .word_o (data_o)
  );

  // R2: a completed read never presents an unknown byte
  a_r2_data_known: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> !$isunknown(data_o));
endmodule

// File: tb/ilv_read_top_bench.sv
`timescale 1ns/1ps
module ilv_read_top_bench;
  localparam int DEPTH = 512;

  logic        clk;
  logic        rst_n;
  logic        req;
  logic [14:0] addr;
  logic [7:0]  data_o;
  logic        done_o;
  logic        pre_we;
  logic [12:0] pre_row;
  logic [1:0]  pre_bank;
  logic [7:0]  pre_data;

  int total;
  int bad;
  bit chk_en;

  // behavioural reference state
  int    ref_mem [4][DEPTH];
  int    m_hold [4];
  bit    m_busy, m_valid, m_done;
  int    m_row, m_sel, m_data;
  string m_tag;

  ilv_read_top #(.BANK_DEPTH(DEPTH)) u_ilv_read_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req),
    .addr_i    (addr),
    .data_o    (data_o),
    .done_o    (done_o),
    .pre_we_i  (pre_we),
    .pre_row_i (pre_row),
    .pre_bank_i(pre_bank),
    .pre_data_i(pre_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: fetch reads before any preload write of the same edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        for (int b = 0; b < 4; b++) m_hold[b] = ref_mem[b][m_row % DEPTH];
        m_valid = 1; m_busy = 0; m_done = 1;
        m_data = m_hold[m_sel]; m_tag = "R3";
      end else if (req) begin
        m_sel = int'(addr[1:0]);
        if (m_valid && int'(addr[14:2]) == m_row) begin
          m_done = 1; m_data = m_hold[m_sel]; m_tag = "R4";
        end else begin
          m_row = int'(addr[14:2]); m_busy = 1;
        end
      end
      if (pre_we) ref_mem[pre_bank][int'(pre_row) % DEPTH] = int'(pre_data);
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      check(done_o === m_done, m_done ? m_tag : "R8", int'(done_o), int'(m_done));
      if (m_done) check(data_o === 8'(m_data), m_tag, int'(data_o), m_data);
    end
  end

  task automatic pre_write(input int row, input int bank, input int val);
    pre_we = 1; pre_row = 13'(row); pre_bank = 2'(bank); pre_data = 8'(val);
    @(negedge clk);
    pre_we = 0;
  endtask

  task automatic do_req(input int row, input int bank, input int exp_lat, input string tag);
    int lat;
    req = 1; addr = {13'(row), 2'(bank)};
    @(negedge clk);
    req = 0;
    lat = 1;
    while (done_o !== 1'b1 && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check(lat == exp_lat, tag, lat, exp_lat);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0; chk_en = 0;
    rst_n = 0; req = 0; addr = '0;
    pre_we = 0; pre_row = '0; pre_bank = '0; pre_data = '0;
    repeat (5) @(negedge clk);
    check(done_o === 1'b0, "R1", int'(done_o), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(done_o === 1'b0, "R1", int'(done_o), 0);
    chk_en = 1;

    // preload rows 0..7, R9 port, row 0 bank 0 nonzero
    for (int r = 0; r < 8; r++)
      for (int b = 0; b < 4; b++)
        pre_write(r, b, (r * 37 + b * 11 + 1) & 255);
    repeat (2) @(negedge clk);
    check(done_o === 1'b0, "R1", int'(done_o), 0);

    // R6: cold row 0 must miss
    do_req(0, 0, 2, "R6");
    // R5: rest of row 0 is held
    do_req(0, 1, 1, "R5");
    do_req(0, 2, 1, "R5");
    do_req(0, 3, 1, "R5");
    // R3 then R5
    do_req(3, 2, 2, "R3");
    do_req(3, 0, 1, "R5");

    // R2: walk rows, banks in scrambled order
    for (int r = 4; r < 8; r++) begin
      do_req(r, 3, 2, "R2");
      do_req(r, 0, 1, "R2");
      do_req(r, 2, 1, "R2");
      do_req(r, 1, 1, "R2");
    end

    // R4: bank changed behind held row 7, hit must return old byte
    pre_write(7, 1, 8'h5A);
    do_req(7, 1, 1, "R4");
    // R9: after leaving and returning, new byte appears
    do_req(6, 0, 2, "R9");
    do_req(7, 1, 2, "R9");

    // R10: row 0x1000 aliases row 0 storage but differs in bit 12
    do_req(0, 0, 2, "R10");
    pre_write(13'h1000, 0, 8'hC3);
    do_req(13'h1000, 0, 2, "R10");

    // R7: second strobe during the fetch is dropped
    req = 1; addr = {13'd2, 2'd0};
    @(negedge clk);
    addr = {13'd5, 2'd3};
    @(negedge clk);
    req = 0;
    check(done_o === 1'b1, "R7", int'(done_o), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(done_o === 1'b0, "R7", int'(done_o), 0);
    end
    do_req(2, 3, 1, "R7");

    // R8: hits on consecutive cycles complete on consecutive cycles
    req = 1; addr = {13'd2, 2'd1};
    @(negedge clk);
    addr = {13'd2, 2'd2};
    check(done_o === 1'b1, "R8", int'(done_o), 1);
    @(negedge clk);
    req = 0;
    check(done_o === 1'b1, "R8", int'(done_o), 1);
    @(negedge clk);
    check(done_o === 1'b0, "R8", int'(done_o), 0);
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule